// File: doc/BRIEF.md
# Dual-Lane Accumulator Interpolator

This block is a register-mapped arithmetic helper that steps through tables or coordinate spaces without software doing the shifts and masks. It holds two accumulators, one per lane, and three base values. Each lane shifts its accumulator right and keeps a chosen bit field. It can sign-extend that field, then adds its own base to form the lane result. A third result combines both lane fields with the third base.

Software reaches the block through a single-cycle register bus. A read is combinational within the access cycle. The block distinguishes reads that only observe a result from reads that also advance the state. An advancing (pop) read returns the current result and, at the end of the same cycle, loads each lane's result into that lane's accumulator. Repeated pops therefore walk the accumulators one step per access. Add ports give single-cycle read-modify-write increments. A paired base port loads both lane bases from one 32-bit word.

Top module: `lane_interp_unit`

## Requirements
- R1: After reset, accumulators and all three bases read 0, and both lane control registers read 0x7C00: shift 0, field [31:0], unsigned.
- R2: Lane control layout: bits [4:0] shift amount, [9:5] low field bit, [14:10] high field bit, [15] signed. The lane field value is (accumulator >> shift) with bits outside [high:low] cleared. It is 0 when low > high. It is readable at address 13 for lane 0 and 14 for lane 1.
- R3: With the signed bit set, every bit of the field value above the high field bit copies bit [high] of the masked value.
- R4: Lane result = field value + lane base (mod 2^32). It is read at address 8 or 5 for lane 0, and 9 or 6 for lane 1.
- R5: The combined result = base2 + lane 0 field value + lane 1 field value (mod 2^32). It is read at address 10 or 7.
- R6: A read at 5, 6 or 7 returns the value computed from the state before the access. On the next cycle, accumulator 0 holds the old lane 0 result and accumulator 1 holds the old lane 1 result. Back-to-back such reads advance one step each.
- R7: A read at 8, 9 or 10 leaves every accumulator, base and control register unchanged.
- R8: A write at 13 or 14 adds the written word to accumulator 0 or 1, wrapping mod 2^32, in one cycle. The other accumulator is left unchanged.
- R9: A write at 15 loads bits [15:0] into base 0 and bits [31:16] into base 1 in the same cycle. Each half is sign-extended when that lane's signed bit is set and zero-extended otherwise.
- R10: A write at 5 to 10 changes no state. A read at 15 returns 0. Bus output is 0 when no read is active. An idle bus changes no state.
- R11: Addresses 0 and 1 (accumulators), 2, 3 and 4 (base 0, 1, 2) read back the last word written. Addresses 11 and 12 (lane controls) keep bits [15:0] and read 0 above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |

## Verification
A wrong accumulator, base or control value shows in the same cycle on any result read, because every read is combinational from the current state. A wrong side effect of a pop, add or paired base write shows on the first access after it. The bench's behavioural model predicts every read and compares it in every access cycle. Drift cannot hide beyond one access, and back-to-back pops expose a double or missing step immediately.

// File: rtl/lane_interp_pkg.sv
package lane_interp_pkg;

  typedef enum logic [3:0] {
    RD_ZERO  = 4'd0,
    RD_ACC0  = 4'd1,
    RD_ACC1  = 4'd2,
    RD_BASE0 = 4'd3,
    RD_BASE1 = 4'd4,
    RD_BASE2 = 4'd5,
    RD_CTRL0 = 4'd6,
    RD_CTRL1 = 4'd7,
    RD_LANE0 = 4'd8,
    RD_LANE1 = 4'd9,
    RD_FULL  = 4'd10,
    RD_RAW0  = 4'd11,
    RD_RAW1  = 4'd12
  } readSelE;

  // Register word addresses; results and side effects depend on these codes.
  localparam logic [3:0] ADR_ACC0     = 4'd0;
  localparam logic [3:0] ADR_ACC1     = 4'd1;
  localparam logic [3:0] ADR_BASE0    = 4'd2;
  localparam logic [3:0] ADR_BASE1    = 4'd3;
  localparam logic [3:0] ADR_BASE2    = 4'd4;
  localparam logic [3:0] ADR_POP0     = 4'd5;
  localparam logic [3:0] ADR_POP1     = 4'd6;
  localparam logic [3:0] ADR_POPF     = 4'd7;
  localparam logic [3:0] ADR_PEEK0    = 4'd8;
  localparam logic [3:0] ADR_PEEK1    = 4'd9;
  localparam logic [3:0] ADR_PEEKF    = 4'd10;
  localparam logic [3:0] ADR_CTRL0    = 4'd11;
  localparam logic [3:0] ADR_CTRL1    = 4'd12;
  localparam logic [3:0] ADR_ADD0     = 4'd13;
  localparam logic [3:0] ADR_ADD1     = 4'd14;
  localparam logic [3:0] ADR_BASEPAIR = 4'd15;

  typedef struct packed {
    logic [1:0] wrAcc;
    logic [2:0] wrBase;
    logic [1:0] wrCtrl;
    logic [1:0] addAcc;
    logic       wrBasePair;
    logic       pop;
    readSelE    rdSel;
  } strobeT;

endpackage

// File: rtl/interp_lane.sv
module interp_lane #(
  parameter int WORD_W = 32,
  localparam int SH_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] accum,
  input  logic [WORD_W-1:0] base,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic [SH_W-1:0]   fieldLo,
  input  logic [SH_W-1:0]   fieldHi,
  input  logic              signedEn,
  output logic [WORD_W-1:0] rawVal,
  output logic [WORD_W-1:0] laneVal
);

  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] keepBits;
  logic [WORD_W-1:0] aboveBits;
  logic [WORD_W-1:0] masked;
  logic              topBit;

  assign shifted = accum >> shiftAmt;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    localparam logic [SH_W-1:0] IDX = SH_W'(i);
    assign keepBits[i]  = (IDX >= fieldLo) && (IDX <= fieldHi);
    assign aboveBits[i] = (IDX > fieldHi);
  end

  assign masked = shifted & keepBits;
  assign topBit = masked[fieldHi];

  always_comb begin
    if (signedEn && topBit) rawVal = masked | aboveBits;
    else                    rawVal = masked;
  end

  assign laneVal = rawVal + base;

endmodule

// File: rtl/interp_ctrl.sv
module interp_ctrl
  import lane_interp_pkg::*;
(
  input  logic       busSel,
  input  logic       busWrite,
  input  logic [3:0] busAddr,
  output strobeT     stb
);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_ZERO;
    if (busSel && busWrite) begin
      case (busAddr)
        ADR_ACC0:     stb.wrAcc[0]   = 1'b1;
        ADR_ACC1:     stb.wrAcc[1]   = 1'b1;
        ADR_BASE0:    stb.wrBase[0]  = 1'b1;
        ADR_BASE1:    stb.wrBase[1]  = 1'b1;
        ADR_BASE2:    stb.wrBase[2]  = 1'b1;
        ADR_CTRL0:    stb.wrCtrl[0]  = 1'b1;
        ADR_CTRL1:    stb.wrCtrl[1]  = 1'b1;
        ADR_ADD0:     stb.addAcc[0]  = 1'b1;
        ADR_ADD1:     stb.addAcc[1]  = 1'b1;
        ADR_BASEPAIR: stb.wrBasePair = 1'b1;
        default:      ;
      endcase
    end else if (busSel) begin
      case (busAddr)
        ADR_ACC0:  stb.rdSel = RD_ACC0;
        ADR_ACC1:  stb.rdSel = RD_ACC1;
        ADR_BASE0: stb.rdSel = RD_BASE0;
        ADR_BASE1: stb.rdSel = RD_BASE1;
        ADR_BASE2: stb.rdSel = RD_BASE2;
        ADR_POP0:  begin stb.rdSel = RD_LANE0; stb.pop = 1'b1; end
        ADR_POP1:  begin stb.rdSel = RD_LANE1; stb.pop = 1'b1; end
        ADR_POPF:  begin stb.rdSel = RD_FULL;  stb.pop = 1'b1; end
        ADR_PEEK0: stb.rdSel = RD_LANE0;
        ADR_PEEK1: stb.rdSel = RD_LANE1;
        ADR_PEEKF: stb.rdSel = RD_FULL;
        ADR_CTRL0: stb.rdSel = RD_CTRL0;
        ADR_CTRL1: stb.rdSel = RD_CTRL1;
        ADR_ADD0:  stb.rdSel = RD_RAW0;
        ADR_ADD1:  stb.rdSel = RD_RAW1;
        default:   stb.rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/interp_datapath.sv
module interp_datapath
  import lane_interp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 stb,
  input  logic [WORD_W-1:0]      wdata,
  output logic [WORD_W-1:0]      rdata,
  output logic [1:0][WORD_W-1:0] accOut,
  output logic [2:0][WORD_W-1:0] baseOut,
  output logic [1:0][WORD_W-1:0] laneOut,
  output logic [1:0]             signedOut
);

  localparam int SH_W   = $clog2(WORD_W);
  localparam int CTRL_W = 3 * SH_W + 1;
  localparam int HALF_W = WORD_W / 2;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'((WORD_W - 1) << (2 * SH_W));

  logic [1:0][WORD_W-1:0] accQ;
  logic [1:0][WORD_W-1:0] rawV;
  logic [1:0][WORD_W-1:0] laneV;
  logic [1:0][WORD_W-1:0] baseLaneQ;
  logic [1:0][CTRL_W-1:0] ctrlQ;
  logic [WORD_W-1:0]      base2Q;
  logic [WORD_W-1:0]      fullV;

  for (genvar j = 0; j < 2; j++) begin : g_lane
    logic [WORD_W-1:0] accR;
    logic [WORD_W-1:0] baseR;
    logic [CTRL_W-1:0] ctrlR;
    logic [HALF_W-1:0] halfBits;
    logic [WORD_W-1:0] pairExt;
    logic              isSigned;

    assign isSigned = ctrlR[CTRL_W-1];
    assign halfBits = wdata[j*HALF_W +: HALF_W];
    assign pairExt  = isSigned ? {{(WORD_W-HALF_W){halfBits[HALF_W-1]}}, halfBits}
                               : {{(WORD_W-HALF_W){1'b0}}, halfBits};

    interp_lane #(.WORD_W(WORD_W)) u_lane (
      .accum    (accR),
      .base     (baseR),
      .shiftAmt (ctrlR[SH_W-1:0]),
      .fieldLo  (ctrlR[2*SH_W-1:SH_W]),
      .fieldHi  (ctrlR[3*SH_W-1:2*SH_W]),
      .signedEn (isSigned),
      .rawVal   (rawV[j]),
      .laneVal  (laneV[j])
    );

    always_ff @(posedge clk) begin
      if (!rstN)              accR <= '0;
      else if (stb.pop)       accR <= laneV[j];
      else if (stb.addAcc[j]) accR <= accR + wdata;
      else if (stb.wrAcc[j])  accR <= wdata;
    end

    always_ff @(posedge clk) begin
      if (!rstN)              baseR <= '0;
      else if (stb.wrBasePair) baseR <= pairExt;
      else if (stb.wrBase[j])  baseR <= wdata;
    end

    always_ff @(posedge clk) begin
      if (!rstN)              ctrlR <= CTRL_RST;
      else if (stb.wrCtrl[j]) ctrlR <= wdata[CTRL_W-1:0];
    end

    assign accQ[j]      = accR;
    assign baseLaneQ[j] = baseR;
    assign ctrlQ[j]     = ctrlR;
    assign signedOut[j] = isSigned;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             base2Q <= '0;
    else if (stb.wrBase[2]) base2Q <= wdata;
  end

  assign fullV = base2Q + rawV[0] + rawV[1];

  always_comb begin
    case (stb.rdSel)
      RD_ACC0:  rdata = accQ[0];
      RD_ACC1:  rdata = accQ[1];
      RD_BASE0: rdata = baseLaneQ[0];
      RD_BASE1: rdata = baseLaneQ[1];
      RD_BASE2: rdata = base2Q;
      RD_CTRL0: rdata = WORD_W'(ctrlQ[0]);
      RD_CTRL1: rdata = WORD_W'(ctrlQ[1]);
      RD_LANE0: rdata = laneV[0];
      RD_LANE1: rdata = laneV[1];
      RD_FULL:  rdata = fullV;
      RD_RAW0:  rdata = rawV[0];
      RD_RAW1:  rdata = rawV[1];
      default:  rdata = '0;
    endcase
  end

  assign accOut  = accQ;
  assign baseOut = {base2Q, baseLaneQ[1], baseLaneQ[0]};
  assign laneOut = laneV;

endmodule

// File: rtl/lane_interp_unit.sv
module lane_interp_unit
  import lane_interp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [3:0]        busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata
);

  strobeT                 stb;
  logic [1:0][WORD_W-1:0] accV;
  logic [2:0][WORD_W-1:0] baseV;
  logic [1:0][WORD_W-1:0] laneV;
  logic [1:0]             signedV;

  interp_ctrl u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .stb      (stb)
  );

  interp_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wdata     (busWdata),
    .rdata     (busRdata),
    .accOut    (accV),
    .baseOut   (baseV),
    .laneOut   (laneV),
    .signedOut (signedV)
  );

endmodule

// File: rtl/interp_checker.sv
module interp_checker #(
  parameter int WORD_W = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busSel,
  input logic                   busWrite,
  input logic [3:0]             busAddr,
  input logic [WORD_W-1:0]      busWdata,
  input logic [1:0][WORD_W-1:0] accV,
  input logic [2:0][WORD_W-1:0] baseV,
  input logic [1:0][WORD_W-1:0] laneV,
  input logic [1:0]             signedV
);

  localparam int HALF_W = WORD_W / 2;

  logic isPop, isPeek, isAdd0, isPair, isDeadWrite;
  assign isPop       = busSel && !busWrite && (busAddr >= 4'd5) && (busAddr <= 4'd7);
  assign isPeek      = busSel && !busWrite && (busAddr >= 4'd8) && (busAddr <= 4'd10);
  assign isAdd0      = busSel && busWrite && (busAddr == 4'd13);
  assign isPair      = busSel && busWrite && (busAddr == 4'd15);
  assign isDeadWrite = busSel && busWrite && (busAddr >= 4'd5) && (busAddr <= 4'd10);

  assert_pop_feedback_R6: assert property (@(posedge clk) disable iff (!rstN)
    isPop |=> (accV[0] == $past(laneV[0])) && (accV[1] == $past(laneV[1])));

  assert_peek_no_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    isPeek |=> $stable(accV) && $stable(baseV) && $stable(signedV));

  assert_add_atomic_R8: assert property (@(posedge clk) disable iff (!rstN)
    isAdd0 |=> (accV[0] == $past(accV[0]) + $past(busWdata)) && $stable(accV[1]));

  assert_pair_halves_R9: assert property (@(posedge clk) disable iff (!rstN)
    isPair |=> (baseV[0][HALF_W-1:0] == $past(busWdata[HALF_W-1:0])) &&
               (baseV[1][HALF_W-1:0] == $past(busWdata[WORD_W-1:HALF_W])) &&
               $stable(baseV[2]));

  assert_pair_zero_ext_R9: assert property (@(posedge clk) disable iff (!rstN)
    (isPair && !signedV[0]) |=> (baseV[0][WORD_W-1:HALF_W] == '0));

  assert_dead_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (isDeadWrite || !busSel) |=> $stable(accV) && $stable(baseV) && $stable(signedV));

endmodule

bind lane_interp_unit interp_checker #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .accV     (accV),
  .baseV    (baseV),
  .laneV    (laneV),
  .signedV  (signedV)
);

// File: tb/tb_lane_interp_unit.sv
module tb_lane_interp_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int applied = 0;
  int miss = 0;
  bit finished = 1'b0;

  logic [31:0] mAcc [2];
  logic [31:0] mBase [3];
  logic [15:0] mCtrl [2];

  always #10 clk = ~clk;

  lane_interp_unit #(.WORD_W(32)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic logic [31:0] fieldOf(int j);
    logic [31:0] sh;
    logic [31:0] r;
    int lo, hi;
    sh = mAcc[j] >> mCtrl[j][4:0];
    lo = int'(mCtrl[j][9:5]);
    hi = int'(mCtrl[j][14:10]);
    r = '0;
    for (int i = 0; i < 32; i++) if (i >= lo && i <= hi) r[i] = sh[i];
    if (mCtrl[j][15]) for (int i = hi + 1; i < 32; i++) r[i] = r[hi];
    return r;
  endfunction

  function automatic logic [31:0] expRead(int a);
    case (a)
      0: return mAcc[0];
      1: return mAcc[1];
      2: return mBase[0];
      3: return mBase[1];
      4: return mBase[2];
      5, 8: return fieldOf(0) + mBase[0];
      6, 9: return fieldOf(1) + mBase[1];
      7, 10: return mBase[2] + fieldOf(0) + fieldOf(1);
      11: return {16'h0, mCtrl[0]};
      12: return {16'h0, mCtrl[1]};
      13: return fieldOf(0);
      14: return fieldOf(1);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] extHalf(logic [15:0] h, logic s);
    return s ? {{16{h[15]}}, h} : {16'h0, h};
  endfunction

  task automatic modelStep(bit wr, int a, logic [31:0] d);
    logic [31:0] l0, l1;
    l0 = fieldOf(0) + mBase[0];
    l1 = fieldOf(1) + mBase[1];
    if (wr) begin
      case (a)
        0, 1: mAcc[a] = d;
        2, 3, 4: mBase[a-2] = d;
        11, 12: mCtrl[a-11] = d[15:0];
        13, 14: mAcc[a-13] = mAcc[a-13] + d;
        15: begin
          mBase[0] = extHalf(d[15:0], mCtrl[0][15]);
          mBase[1] = extHalf(d[31:16], mCtrl[1][15]);
        end
        default: ;
      endcase
    end else if (a >= 5 && a <= 7) begin
      mAcc[0] = l0;
      mAcc[1] = l1;
    end
  endtask

  task automatic access(bit wr, int a, logic [31:0] d, string tag);
    logic [31:0] e;
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busAddr = a[3:0]; busWdata = d;
    #5;
    e = wr ? 32'h0 : expRead(a);
    applied++;
    if (busRdata !== e) begin
      miss++;
      $display("FAIL %s addr %0d wr %0d actual %h expected %h", tag, a, wr, busRdata, e);
    end
    @(posedge clk);
    modelStep(wr, a, d);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = 32'hDEAD_BEEF;
    #5;
    applied++;
    if (busRdata !== 32'h0) begin
      miss++;
      $display("FAIL %s idle actual %h expected %h", tag, busRdata, 32'h0);
    end
    @(posedge clk);
  endtask

  task automatic readAll(string tag);
    for (int a = 0; a < 16; a++) access(1'b0, a, 32'h0, tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miss);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    miss++;
    $display("FAIL watchdog actual timeout expected completion");
    finish();
  end

  initial begin
    mAcc[0] = 0; mAcc[1] = 0;
    mBase[0] = 0; mBase[1] = 0; mBase[2] = 0;
    mCtrl[0] = 16'h7C00; mCtrl[1] = 16'h7C00;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    readAll("R1 reset state");

    // R11 plain register read-back
    access(1, 0, 32'h1234_5678, "R11");
    access(1, 1, 32'h9ABC_DEF0, "R11");
    access(1, 2, 32'h0000_0100, "R11");
    access(1, 3, 32'hFFFF_FF00, "R11");
    access(1, 4, 32'h0000_0010, "R11");
    access(1, 12, 32'hFFFF_1234, "R11");
    readAll("R11 readback");

    // R2 shift and field: shift 4, field [11:4]
    access(1, 11, 32'h0000_2C84, "R2");
    access(0, 13, 0, "R2 field lane0");
    access(0, 14, 0, "R2 field lane1");
    // R2 empty field (low 9 > high 3)
    access(1, 11, 32'h0000_0D20, "R2");
    access(0, 13, 0, "R2 empty field");
    // R3 signed field [11:4] with bit 11 set
    access(1, 0, 32'h0000_8F00, "R3");
    access(1, 11, 32'h0000_AC84, "R3");
    access(0, 13, 0, "R3 signed field");
    access(1, 0, 32'h0000_7F00, "R3");
    access(0, 13, 0, "R3 signed positive");
    // R4 and R5 lane and combined results
    access(0, 8, 0, "R4 lane0 peek");
    access(0, 9, 0, "R4 lane1 peek");
    access(0, 10, 0, "R5 full peek");
    // R7 peek leaves state
    access(0, 8, 0, "R7");
    access(0, 10, 0, "R7");
    readAll("R7 after peek");

    // R6 back-to-back pops: identity lanes, base0 = 1, base1 = 3
    access(1, 11, 32'h0000_7C00, "R6");
    access(1, 12, 32'h0000_7C00, "R6");
    access(1, 0, 32'h0, "R6");
    access(1, 1, 32'h10, "R6");
    access(1, 2, 32'h1, "R6");
    access(1, 3, 32'h3, "R6");
    access(0, 5, 0, "R6 pop lane0");
    access(0, 5, 0, "R6 pop lane0");
    access(0, 6, 0, "R6 pop lane1");
    access(0, 7, 0, "R6 pop full");
    access(0, 0, 0, "R6 acc0 after pops");
    access(0, 1, 0, "R6 acc1 after pops");

    // R8 atomic add with wrap
    access(1, 13, 32'hFFFF_FFFF, "R8");
    access(0, 0, 0, "R8 acc0 wrap");
    access(0, 1, 0, "R8 acc1 untouched");
    access(1, 14, 32'h8000_0001, "R8");
    access(0, 1, 0, "R8 acc1 add");

    // R9 paired base: lane0 unsigned, lane1 signed
    access(1, 12, 32'h0000_FC00, "R9");
    access(1, 15, 32'h8001_F00F, "R9");
    access(0, 2, 0, "R9 base0 zero ext");
    access(0, 3, 0, "R9 base1 sign ext");
    access(1, 11, 32'h0000_FC00, "R9");
    access(1, 12, 32'h0000_7C00, "R9");
    access(1, 15, 32'h7FFF_8000, "R9");
    access(0, 2, 0, "R9 base0 sign ext");
    access(0, 3, 0, "R9 base1 zero ext");

    // R10 writes to result addresses, read of pair port, idle
    for (int a = 5; a <= 10; a++) access(1, a, 32'h5555_AAAA, "R10");
    readAll("R10 after dead writes");
    idle("R10");
    idle("R10");
    readAll("R10 after idle");

    // mixed traffic: R2 R4 R5 R6 R7 R8 R9
    for (int n = 0; n < 600; n++) begin
      int a;
      bit wr;
      a = int'($urandom_range(0, 15));
      wr = $urandom_range(0, 2) == 0;
      if (n % 17 == 0) idle("mixed R10");
      access(wr, a, $urandom, "mixed R6 R8");
    end
    readAll("mixed final R4 R5");

    finish();
  end

endmodule